// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Register Views

This block holds the three machine-level interrupt control words of a hart: the enable word, the pending word and the delegation word. Every access names one of eight views and carries a read-modify-write request made of a data word and a write mask. The block returns the old value of that view in the same cycle. At the next rising clock edge it commits the masked update to the underlying word.

The views apply the masking and the one-position bit shift that each privilege layer needs. The machine views see the raw words. The supervisor enable view and the supervisor pending view move their bits between the supervisor slot and the virtual-supervisor slot while the virtualization flag is set. The hypervisor views reach only the virtual-supervisor bits. A separate virtual-supervisor pending view writes only the virtual software bit. Two inputs shape the writes. The hypervisor-present flag forces the virtual-supervisor delegation bits to one on every delegation write. The hardware-claim mask shields pending bits from every software write.

Bit positions are fixed, because the shift between slots depends on them. Supervisor bits sit at 1, 5 and 9. Virtual-supervisor bits sit at 2, 6 and 10. Machine bits sit at 3, 7 and 11. The delegable set is the supervisor set plus the virtual-supervisor set, which is mask 0x666. The full set is mask 0xEEE. The view select is encoded as follows: 0 machine enable, 1 machine pending, 2 delegation, 3 supervisor enable, 4 supervisor pending, 5 hypervisor enable, 6 hypervisor pending, 7 virtual-supervisor pending. Let merged = (old view value AND NOT mask) OR (data AND mask).

Top module: `irq_view_regs`

## Requirements
- R1: After reset the enable, pending and delegation words are all zero.
- R2: View 0 returns the enable word. A write sets enable bits in mask 0xEEE to merged and leaves every other bit at zero.
- R3: View 2 returns the delegation word. A write sets bits in mask 0x666 to merged. When hypervisor-present is 1, bits 2, 6 and 10 become 1 after the write.
- R4: View 1 returns the pending word. A write changes only the bits in (mask AND 0x666 AND NOT claim), and those bits take the data value.
- R5: View 3 with virtualization off returns (enable AND delegation). A write sets enable bits 1, 5 and 9 to merged and leaves the other enable bits unchanged.
- R6: View 3 with virtualization on returns (enable AND delegation AND 0x444) shifted right by one. A write sets enable bits 2, 6 and 10 to (merged shifted left by one) and leaves the other enable bits unchanged.
- R7: View 4 with virtualization off returns (pending AND delegation). A write can change only pending bit 1, and only where delegation bit 1 is 1 and claim bit 1 is 0.
- R8: View 4 with virtualization on returns (pending AND delegation AND 0x004). A write shifts mask bit 1 and the data left by one, so it can change only pending bit 2, and only where delegation bit 2 is 1 and claim bit 2 is 0.
- R9: View 5 returns (enable AND 0x444). A write sets enable bits 2, 6 and 10 to merged and leaves the other enable bits unchanged.
- R10: View 6 returns the pending word. A write can change only pending bits 2, 6 and 10 that are not claimed.
- R11: View 7 returns the pending word. A write can change only pending bit 2, and only where delegation bit 2 is 1 and claim bit 2 is 0.
- R12: An access with the enable input low, or with an all-zero mask, changes no word. This holds even for a delegation access while hypervisor-present is 1.
- R13: The old view value is valid in the cycle of the request. The updated words appear after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request in this cycle |
| acc_view | input | 3 | View select (encoding in R2 to R11) |
| acc_wdata | input | W | New data for the masked update |
| acc_wmask | input | W | Write mask; all zero means read only |
| virt_on | input | 1 | Virtualization flag, used by view 3 and view 4 |
| hyp_present | input | 1 | Hypervisor present; forces the virtual delegation bits on write |
| hw_claim | input | W | Pending bits owned by hardware, never written by software |
| acc_rdata | output | W | Old value of the selected view |
| ien_q | output | W | Interrupt enable word |
| ipend_q | output | W | Interrupt pending word |
| ideleg_q | output | W | Interrupt delegation word |

## Verification
The old view value is combinational, so it is due in the request cycle itself. The three words are registered, so they change one rising edge after the request. The bench drives each request at a falling edge and compares acc_rdata 1 ns later, before any edge. It then compares the three words 1 ns after the following rising edge, and it does not drive a new request until the next falling edge. Directed cases cover the hypervisor forcing, claimed bits, and the shifted supervisor views. A seeded random stream covers the mixed view, flag and mask combinations.

// File: rtl/irq_view_regs.sv
`timescale 1ns/1ps
module irq_view_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_en,
  input  logic [2:0]   acc_view,
  input  logic [W-1:0] acc_wdata,
  input  logic [W-1:0] acc_wmask,
  input  logic         virt_on,
  input  logic         hyp_present,
  input  logic [W-1:0] hw_claim,
  output logic [W-1:0] acc_rdata,
  output logic [W-1:0] ien_q,
  output logic [W-1:0] ipend_q,
  output logic [W-1:0] ideleg_q
);
  localparam logic [W-1:0] SUP_SET  = W'(12'h222);
  localparam logic [W-1:0] VIRT_SET = W'(12'h444);
  localparam logic [W-1:0] MACH_SET = W'(12'h888);
  localparam logic [W-1:0] DLG_SET  = SUP_SET | VIRT_SET;
  localparam logic [W-1:0] ALL_SET  = DLG_SET | MACH_SET;
  localparam logic [W-1:0] SSW_BIT  = W'(12'h002);
  localparam logic [W-1:0] VSSW_BIT = W'(12'h004);

  localparam logic [2:0] V_MEN = 3'd0, V_MPEND = 3'd1, V_DELEG = 3'd2, V_SEN = 3'd3,
                         V_SPEND = 3'd4, V_HEN = 3'd5, V_HPEND = 3'd6, V_VSPEND = 3'd7;

  logic         do_wr;
  logic [W-1:0] merged;
  logic [W-1:0] pm_raw, pv, pmask;
  logic [W-1:0] en_nxt, pd_nxt, dl_nxt;

  assign do_wr  = acc_en && (acc_wmask != '0);
  assign merged = (acc_rdata & ~acc_wmask) | (acc_wdata & acc_wmask);
  assign pmask  = pm_raw & DLG_SET & ~hw_claim;

  always_comb begin
    acc_rdata = '0;
    case (acc_view)
      V_MEN:    acc_rdata = ien_q;
      V_MPEND:  acc_rdata = ipend_q;
      V_DELEG:  acc_rdata = ideleg_q;
      V_SEN:    acc_rdata = virt_on ? ((ien_q & ideleg_q & VIRT_SET) >> 1) : (ien_q & ideleg_q);
      V_SPEND:  acc_rdata = virt_on ? (ipend_q & ideleg_q & VSSW_BIT) : (ipend_q & ideleg_q);
      V_HEN:    acc_rdata = ien_q & VIRT_SET;
      default:  acc_rdata = ipend_q;
    endcase
  end

  always_comb begin
    pm_raw = '0;
    pv     = acc_wdata;
    case (acc_view)
      V_MPEND:  pm_raw = acc_wmask;
      V_SPEND:
        if (virt_on) begin
          pm_raw = ((acc_wmask & SSW_BIT) << 1) & ideleg_q;
          pv     = acc_wdata << 1;
        end else begin
          pm_raw = acc_wmask & SSW_BIT & ideleg_q;
        end
      V_HPEND:  pm_raw = acc_wmask & VIRT_SET;
      V_VSPEND: pm_raw = acc_wmask & ideleg_q & VSSW_BIT;
      default:  pm_raw = '0;
    endcase
  end

  always_comb begin
    en_nxt = ien_q;
    dl_nxt = ideleg_q;
    pd_nxt = (ipend_q & ~pmask) | (pv & pmask);
    case (acc_view)
      V_MEN:   en_nxt = (ien_q & ~ALL_SET) | (merged & ALL_SET);
      V_DELEG: dl_nxt = (ideleg_q & ~DLG_SET) | (merged & DLG_SET) | (hyp_present ? VIRT_SET : '0);
      V_SEN:   en_nxt = virt_on ? ((ien_q & ~VIRT_SET) | ((merged << 1) & VIRT_SET))
                                : ((ien_q & ~SUP_SET) | (merged & SUP_SET));
      V_HEN:   en_nxt = (ien_q & ~VIRT_SET) | (merged & VIRT_SET);
      default: en_nxt = ien_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= '0;
      ipend_q  <= '0;
      ideleg_q <= '0;
    end else if (do_wr) begin
      ien_q    <= en_nxt;
      ipend_q  <= pd_nxt;
      ideleg_q <= dl_nxt;
    end
  end
endmodule

// File: rtl/irq_view_regs_chk.sv
`timescale 1ns/1ps
module irq_view_regs_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_en,
  input logic [2:0]   acc_view,
  input logic [W-1:0] acc_wdata,
  input logic [W-1:0] acc_wmask,
  input logic         virt_on,
  input logic         hyp_present,
  input logic [W-1:0] hw_claim,
  input logic [W-1:0] acc_rdata,
  input logic [W-1:0] ien_q,
  input logic [W-1:0] ipend_q,
  input logic [W-1:0] ideleg_q
);
  localparam logic [W-1:0] VIRT_SET = W'(12'h444);
  localparam logic [W-1:0] DLG_SET  = W'(12'h666);
  localparam logic [W-1:0] ALL_SET  = W'(12'hEEE);
  localparam logic [W-1:0] VSSW_BIT = W'(12'h004);

  logic unused_ok;
  assign unused_ok = ^acc_wdata;

  assert_en_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q & ~ALL_SET) == '0);

  assert_deleg_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ideleg_q & ~DLG_SET) == '0);

  assert_vs_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_view == 3'd2 && acc_wmask != '0 && hyp_present)
      |=> ((ideleg_q & VIRT_SET) == VIRT_SET));

  assert_pend_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ipend_q & ~DLG_SET) == '0);

  assert_claim_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> (((ipend_q ^ $past(ipend_q)) & $past(hw_claim)) == '0));

  assert_spend_virt_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_view == 3'd4 && virt_on) |-> ((acc_rdata & ~VSSW_BIT) == '0));

  assert_hen_only_vs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_view == 3'd5)
      |=> (((ien_q ^ $past(ien_q)) & ~VIRT_SET) == '0));

  assert_vspend_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_view == 3'd7)
      |=> (((ipend_q ^ $past(ipend_q)) & ~VSSW_BIT) == '0));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en || acc_wmask == '0)
      |=> ($stable(ien_q) && $stable(ipend_q) && $stable(ideleg_q)));
endmodule

bind irq_view_regs irq_view_regs_chk #(.W(W)) u_chk (.*);

// File: tb/irq_view_regs_tb.sv
`timescale 1ns/1ps
module irq_view_regs_tb;
  localparam int W = 32;
  localparam logic [W-1:0] SUP_SET  = 32'h222;
  localparam logic [W-1:0] VIRT_SET = 32'h444;
  localparam logic [W-1:0] DLG_SET  = 32'h666;
  localparam logic [W-1:0] ALL_SET  = 32'hEEE;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_en = 1'b0;
  logic [2:0]   acc_view = '0;
  logic [W-1:0] acc_wdata = '0, acc_wmask = '0, hw_claim = '0;
  logic         virt_on = 1'b0, hyp_present = 1'b0;
  logic [W-1:0] acc_rdata, ien_q, ipend_q, ideleg_q;

  int  total = 0, bad = 0;
  bit  finished = 1'b0;
  logic [W-1:0] m_en = '0, m_pd = '0, m_dl = '0;

  always #2.5 clk = ~clk;

  irq_view_regs #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_view(acc_view),
    .acc_wdata(acc_wdata), .acc_wmask(acc_wmask), .virt_on(virt_on),
    .hyp_present(hyp_present), .hw_claim(hw_claim), .acc_rdata(acc_rdata),
    .ien_q(ien_q), .ipend_q(ipend_q), .ideleg_q(ideleg_q));

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int view, input bit virt);
    case (view)
      0: return "R2";
      1: return "R4";
      2: return "R3";
      3: return virt ? "R6" : "R5";
      4: return virt ? "R8" : "R7";
      5: return "R9";
      6: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [W-1:0] exp_read(input int view, input bit virt);
    case (view)
      0: return m_en;
      1: return m_pd;
      2: return m_dl;
      3: return virt ? ((m_en & m_dl & VIRT_SET) >> 1) : (m_en & m_dl);
      4: return virt ? (m_pd & m_dl & 32'h004) : (m_pd & m_dl);
      5: return m_en & VIRT_SET;
      default: return m_pd;
    endcase
  endfunction

  task automatic access(input int view, input logic [W-1:0] wd, input logic [W-1:0] wm,
                        input bit virt, input bit hyp, input logic [W-1:0] claim, input bit en);
    logic [W-1:0] er, mg, pm, pv;
    string tg;
    @(negedge clk);
    acc_en = en; acc_view = 3'(view); acc_wdata = wd; acc_wmask = wm;
    virt_on = virt; hyp_present = hyp; hw_claim = claim;
    #1;
    tg = tag_of(view, virt);
    er = exp_read(view, virt);
    chk($sformatf("%s/R13", tg), "old view value", acc_rdata, er);
    if (en && wm != '0) begin
      mg = (er & ~wm) | (wd & wm);
      pm = '0; pv = wd;
      case (view)
        0: m_en = (m_en & ~ALL_SET) | (mg & ALL_SET);
        1: pm = wm;
        2: m_dl = (m_dl & ~DLG_SET) | (mg & DLG_SET) | (hyp ? VIRT_SET : '0);
        3: m_en = virt ? ((m_en & ~VIRT_SET) | ((mg << 1) & VIRT_SET))
                       : ((m_en & ~SUP_SET) | (mg & SUP_SET));
        4: if (virt) begin pm = (wm & 32'h002) << 1; pv = wd << 1; end
           else pm = wm & 32'h002;
        5: m_en = (m_en & ~VIRT_SET) | (mg & VIRT_SET);
        6: pm = wm & VIRT_SET;
        default: pm = wm & 32'h004;
      endcase
      if (view == 4 || view == 7) pm = pm & m_dl;
      pm = pm & DLG_SET & ~claim;
      m_pd = (m_pd & ~pm) | (pv & pm);
    end else begin
      tg = "R12";
    end
    @(posedge clk); #1;
    chk($sformatf("%s/R13", tg), "enable word", ien_q, m_en);
    chk($sformatf("%s/R13", tg), "pending word", ipend_q, m_pd);
    chk($sformatf("%s/R13", tg), "delegation word", ideleg_q, m_dl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1", "enable after reset", ien_q, '0);
    chk("R1", "pending after reset", ipend_q, '0);
    chk("R1", "delegation after reset", ideleg_q, '0);
    rst_n = 1'b1;
    // directed corners
    access(2, '1, '1, 0, 0, '0, 1);                  // R3 without hypervisor
    access(2, '0, 32'h002, 0, 1, '0, 1);             // R3 virtual bits forced
    access(0, '1, '1, 0, 0, '0, 1);                  // R2 full enable
    access(3, '0, 32'h020, 0, 0, '0, 1);             // R5 single bit
    access(3, 32'h222, 32'hFFF, 1, 0, '0, 1);        // R6 shifted write
    access(3, '0, '0, 1, 0, '0, 1);                  // R6 read, R12 no write
    access(1, '1, '1, 0, 0, 32'h200, 1);             // R4 claimed SEIP held
    access(4, '0, 32'h002, 0, 0, '0, 1);             // R7 clear SSIP
    access(4, 32'h002, 32'h002, 1, 0, '0, 1);        // R8 shifted pending
    access(4, 32'h002, 32'h002, 1, 0, 32'h004, 1);   // R8 claimed
    access(6, '0, '1, 0, 0, '0, 1);                  // R10
    access(7, 32'h004, '1, 0, 0, '0, 1);             // R11
    access(5, '0, 32'h040, 0, 0, '0, 1);             // R9
    access(2, '0, '1, 0, 1, '0, 0);                  // R12 enable low
    access(2, '0, '0, 0, 1, '0, 1);                  // R12 zero mask
    access(2, '0, '1, 0, 0, '0, 1);                  // R3 clear all
    access(7, 32'h004, '1, 0, 0, '0, 1);             // R11 undelegated
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] wm;
      case ($urandom % 4)
        0: wm = '0;
        1: wm = '1;
        default: wm = $urandom;
      endcase
      access(int'($urandom % 8), $urandom, wm, bit'($urandom % 2), bit'($urandom % 2),
             $urandom & $urandom & $urandom, ($urandom % 8) != 0);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule